// File: doc/BRIEF.md
# Hardware Return Address Stack

This block stores the return addresses of a small processor core. A call or an interrupt acknowledge presents a push with the address to come back to. A return presents a pop, and the block hands the saved address back to the program counter in the same cycle. The storage has a dedicated pointer. Pointer value zero means "empty" and has no entry behind it. Entries 1 to 31 hold 21-bit addresses.

Software can see and change the stack. It can read and write the pointer. It can read the selected entry as three byte lanes (low, high and upper) and can overwrite any one lane. Two sticky status flags report when the stack has filled and when a pop found it empty. A configuration input chooses the response to overflow. The block can raise a one-cycle reset request and drop the pointer to zero, or it can park at the top entry and discard further pushes. A pop from an empty stack returns address zero, which sends execution to the reset vector.

Push has no back-pressure and is always taken. Pop uses a valid/ready pair. `pop_ready` falls only in a cycle where a push is also requested, so a pop is taken exactly when `pop_valid && pop_ready`. In that cycle `pop_addr` carries the returned address. A refused pop is simply dropped; the requester is not expected to hold it.

Top module: `ret_stack`

## Requirements
- R1: After reset the pointer reads 0, `full`, `underflow` and `rst_req` are low, and all three top-of-stack lanes read 0.
- R2: A push at a pointer below 30 increments the pointer on the next clock and stores the address in the newly selected entry. That value then reads back on the top-of-stack lanes.
- R3: A taken pop at a nonzero pointer drives the selected entry on `pop_addr` in the same cycle and decrements the pointer on the next clock.
- R4: `full` sets on a push taken while the pointer is 30 or 31. It stays set until `clr_full` is pulsed, and a set in the same cycle wins over a clear.
- R5: With `ovf_rst_en` high, a push at pointer 30 stores its address in entry 31 and sets `full`. On the next clock it raises `rst_req` for exactly one cycle and forces the pointer to 0.
- R6: With `ovf_rst_en` low, a push at pointer 30 moves the pointer to 31 and sets `full`. Later pushes leave entry 31 and the pointer unchanged, and `rst_req` stays low.
- R7: A pop taken at pointer 0 returns 0 on `pop_addr` and leaves the pointer at 0. It sets `underflow`, which stays set until `clr_underflow` is pulsed.
- R8: `ptr_wr_en` loads `ptr_wr_val` into the pointer on the next clock. The write is ignored in a cycle where a push or a taken pop also occurs.
- R9: The top-of-stack lanes map to address bits: `tos_wr_lane` 0 is bits 7:0, 1 is bits 15:8, and 2 is bits 20:16. A lane write changes only its own lane. The upper lane keeps 5 bits, so its bits 7:5 read 0 and ignore writes. Lane code 3 is ignored.
- R10: At pointer 0 the top-of-stack lanes read 0, and lane writes are ignored.
- R11: When a push and a pop arrive together, `pop_ready` is low, the pop is dropped and the push is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ovf_rst_en | input | 1 | 1: overflow requests reset; 0: overflow saturates |
| push_valid | input | 1 | Push request (call or interrupt acknowledge) |
| push_addr | input | 21 | Return address to push |
| pop_valid | input | 1 | Pop request (return) |
| pop_ready | output | 1 | Pop can be taken this cycle |
| pop_addr | output | 21 | Returned address for a taken pop |
| ptr_wr_en | input | 1 | Software pointer write strobe |
| ptr_wr_val | input | 5 | Pointer value to write |
| ptr_val | output | 5 | Current pointer |
| tos_wr_en | input | 1 | Software top-of-stack lane write strobe |
| tos_wr_lane | input | 2 | Lane select: 0 low, 1 high, 2 upper |
| tos_wr_byte | input | 8 | Byte to write into the selected lane |
| tos_upper | output | 8 | Selected entry bits 20:16, zero-extended |
| tos_high | output | 8 | Selected entry bits 15:8 |
| tos_low | output | 8 | Selected entry bits 7:0 |
| clr_full | input | 1 | Software clear of the full flag |
| clr_underflow | input | 1 | Software clear of the underflow flag |
| full | output | 1 | Sticky stack-full flag |
| underflow | output | 1 | Sticky underflow flag |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The hardest state to reach is the overflow edge. It needs thirty pushes with no pop in between before the thirty-first push shows either the reset request or saturation. The stimulus reaches it with counted push loops, once in each overflow mode. It then moves the pointer to 31 through a software write, which is the only way to read entry 31 back after the reset-request path has cleared the pointer. The push-with-pop collision and the byte-lane writes at pointer 0 are set up on purpose from known pointer values.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int unsigned LANE_BITS = 8;

  typedef enum logic [1:0] {
    LANE_LOW   = 2'd0,
    LANE_HIGH  = 2'd1,
    LANE_UPPER = 2'd2,
    LANE_NONE  = 2'd3
  } tos_lane_e;

  function automatic int unsigned lanes_for(input int unsigned width);
    return (width + LANE_BITS - 1) / LANE_BITS;
  endfunction
endpackage

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [PTR_W-1:0]  ridx,
  output logic [ADDR_W-1:0] rdata
);
  localparam int unsigned DEPTH = (1 << PTR_W) - 1;

  logic [ADDR_W-1:0] slot [1:DEPTH];

  // One register per entry; index 0 has no storage.
  for (genvar e = 1; e <= DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == PTR_W'(e)) slot[e] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int e = 1; e <= DEPTH; e++) begin
      if (ridx == PTR_W'(e)) rdata = slot[e];
    end
  end
endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl #(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_rst_en,
  input  logic             push_valid,
  input  logic             pop_valid,
  input  logic             ptr_wr_en,
  input  logic [PTR_W-1:0] ptr_wr_val,
  input  logic             clr_full,
  input  logic             clr_underflow,
  output logic [PTR_W-1:0] ptr,
  output logic             pop_take,
  output logic             push_store,
  output logic             sw_slot,
  output logic             full,
  output logic             underflow,
  output logic             rst_req
);
  localparam int unsigned DEPTH = (1 << PTR_W) - 1;
  localparam logic [PTR_W-1:0] TOP  = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] NEAR = PTR_W'(DEPTH - 1);

  logic             at_edge;
  logic             ovf_hit;
  logic             empty_pop;
  logic [PTR_W-1:0] ptr_nxt;

  assign pop_take   = pop_valid && !push_valid;
  assign at_edge    = (ptr == NEAR) || (ptr == TOP);
  assign ovf_hit    = push_valid && at_edge;
  assign push_store = push_valid && (ptr != TOP);
  assign empty_pop  = pop_take && (ptr == '0);
  assign sw_slot    = !push_valid && !pop_take;

  always_comb begin
    ptr_nxt = ptr;
    if (push_valid) begin
      if (at_edge) ptr_nxt = ovf_rst_en ? '0 : TOP;
      else         ptr_nxt = ptr + PTR_W'(1);
    end else if (pop_take) begin
      if (ptr != '0) ptr_nxt = ptr - PTR_W'(1);
    end else if (ptr_wr_en) begin
      ptr_nxt = ptr_wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      full      <= 1'b0;
      underflow <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      ptr     <= ptr_nxt;
      rst_req <= ovf_hit && ovf_rst_en;
      if (ovf_hit)        full <= 1'b1;
      else if (clr_full)  full <= 1'b0;
      if (empty_pop)          underflow <= 1'b1;
      else if (clr_underflow) underflow <= 1'b0;
    end
  end
endmodule

// File: rtl/ret_stack_tos.sv
module ret_stack_tos
  import ret_stack_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic [ADDR_W-1:0]                      cur,
  input  logic [1:0]                             lane,
  input  logic [LANE_BITS-1:0]                   wbyte,
  output logic [ADDR_W-1:0]                      merged,
  output logic                                   lane_ok,
  output logic [lanes_for(ADDR_W)-1:0][LANE_BITS-1:0] rd_lanes
);
  localparam int unsigned NL = lanes_for(ADDR_W);

  assign lane_ok = (32'(lane) < NL) && (tos_lane_e'(lane) != LANE_NONE);

  always_comb begin
    merged = cur;
    for (int b = 0; b < int'(ADDR_W); b++) begin
      if ((b / int'(LANE_BITS)) == int'(lane)) merged[b] = wbyte[b % int'(LANE_BITS)];
    end
  end

  // Each lane is a slice of the word, zero-extended when it is short.
  for (genvar k = 0; k < NL; k++) begin : g_lane
    localparam int unsigned LO = k * LANE_BITS;
    localparam int unsigned LW = ((ADDR_W - LO) < LANE_BITS) ? (ADDR_W - LO) : LANE_BITS;
    if (LW == LANE_BITS) begin : g_full
      assign rd_lanes[k] = cur[LO +: LANE_BITS];
    end else begin : g_part
      assign rd_lanes[k] = {{(LANE_BITS - LW){1'b0}}, cur[LO +: LW]};
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovf_rst_en,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_valid,
  output logic              pop_ready,
  output logic [ADDR_W-1:0] pop_addr,
  input  logic              ptr_wr_en,
  input  logic [PTR_W-1:0]  ptr_wr_val,
  output logic [PTR_W-1:0]  ptr_val,
  input  logic              tos_wr_en,
  input  logic [1:0]        tos_wr_lane,
  input  logic [7:0]        tos_wr_byte,
  output logic [7:0]        tos_upper,
  output logic [7:0]        tos_high,
  output logic [7:0]        tos_low,
  input  logic              clr_full,
  input  logic              clr_underflow,
  output logic              full,
  output logic              underflow,
  output logic              rst_req
);
  localparam int unsigned NL = lanes_for(ADDR_W);

  logic [PTR_W-1:0]  ptr;
  logic              pop_take, push_store, sw_slot;
  logic [ADDR_W-1:0] cur_word, merged;
  logic              lane_ok, tos_we;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_widx;
  logic [ADDR_W-1:0] mem_wdata;
  logic [NL-1:0][LANE_BITS-1:0] rd_lanes;

  ret_stack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en),
    .push_valid(push_valid), .pop_valid(pop_valid),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_val(ptr_wr_val),
    .clr_full(clr_full), .clr_underflow(clr_underflow),
    .ptr(ptr), .pop_take(pop_take), .push_store(push_store), .sw_slot(sw_slot),
    .full(full), .underflow(underflow), .rst_req(rst_req)
  );

  ret_stack_tos #(.ADDR_W(ADDR_W)) u_tos (
    .cur(cur_word), .lane(tos_wr_lane), .wbyte(tos_wr_byte),
    .merged(merged), .lane_ok(lane_ok), .rd_lanes(rd_lanes)
  );

  // Software lane writes only land on a real entry in a quiet cycle.
  assign tos_we    = tos_wr_en && lane_ok && sw_slot && (ptr != '0);
  assign mem_we    = push_store || tos_we;
  assign mem_widx  = push_store ? ptr + PTR_W'(1) : ptr;
  assign mem_wdata = push_store ? push_addr : merged;

  ret_stack_mem #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we(mem_we), .widx(mem_widx), .wdata(mem_wdata),
    .ridx(ptr), .rdata(cur_word)
  );

  assign pop_ready = !push_valid;
  assign pop_addr  = cur_word;
  assign ptr_val   = ptr;
  assign tos_low   = rd_lanes[0];
  assign tos_high  = rd_lanes[1];
  assign tos_upper = rd_lanes[2];
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ovf_rst_en,
  input logic              push_valid,
  input logic [ADDR_W-1:0] push_addr,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic [ADDR_W-1:0] pop_addr,
  input logic [PTR_W-1:0]  ptr_val,
  input logic              clr_full,
  input logic              full,
  input logic              underflow,
  input logic              rst_req,
  input logic [7:0]        tos_upper,
  input logic [7:0]        tos_high,
  input logic [7:0]        tos_low
);
  localparam logic [PTR_W-1:0] TOP  = PTR_W'((1 << PTR_W) - 1);
  localparam logic [PTR_W-1:0] NEAR = PTR_W'((1 << PTR_W) - 2);

  logic [ADDR_W-1:0] tos_word;
  assign tos_word = ADDR_W'({tos_upper, tos_high, tos_low});

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && ptr_val < NEAR) |=> (ptr_val == $past(ptr_val) + PTR_W'(1) && tos_word == $past(push_addr)));

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready && ptr_val != '0) |=> (ptr_val == $past(ptr_val) - PTR_W'(1)));

  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_full) |=> full);

  a_r5_ovf_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && ovf_rst_en && ptr_val == NEAR) |=> (rst_req && full && ptr_val == '0));

  a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !ovf_rst_en && ptr_val == TOP) |=> (ptr_val == TOP && $stable(tos_word) && !rst_req));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready && ptr_val == '0) |-> (pop_addr == '0));

  a_r7_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready && ptr_val == '0) |=> (underflow && ptr_val == '0));

  a_r9_upper_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    tos_upper[7:5] == 3'b000);

  a_r10_empty_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_val == '0) |-> (tos_word == '0));

  a_r11_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !pop_ready);
endmodule

bind ret_stack ret_stack_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf_rst_en(ovf_rst_en),
  .push_valid(push_valid), .push_addr(push_addr),
  .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_addr(pop_addr),
  .ptr_val(ptr_val), .clr_full(clr_full), .full(full), .underflow(underflow),
  .rst_req(rst_req), .tos_upper(tos_upper), .tos_high(tos_high), .tos_low(tos_low)
);

// File: tb/test_ret_stack.sv
`timescale 1ns/1ps
module test_ret_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovf_rst_en = 1'b1;
  logic        push_valid = 1'b0;
  logic [20:0] push_addr = '0;
  logic        pop_valid = 1'b0;
  logic        pop_ready;
  logic [20:0] pop_addr;
  logic        ptr_wr_en = 1'b0;
  logic [4:0]  ptr_wr_val = '0;
  logic [4:0]  ptr_val;
  logic        tos_wr_en = 1'b0;
  logic [1:0]  tos_wr_lane = '0;
  logic [7:0]  tos_wr_byte = '0;
  logic [7:0]  tos_upper, tos_high, tos_low;
  logic        clr_full = 1'b0;
  logic        clr_underflow = 1'b0;
  logic        full, underflow, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [20:0] pop_seen;
  logic        rdy_seen;

  always #2 clk = ~clk;

  ret_stack i_ret_stack (.*);

  function automatic logic [20:0] tos_word();
    return {tos_upper[4:0], tos_high, tos_low};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; sample combinational pop outputs
  // before the rising edge, registered state just after it.
  task automatic cyc(input logic psh, input logic pp, input logic [20:0] d,
                     input logic pwe = 0, input logic [4:0] pv = 0,
                     input logic twe = 0, input logic [1:0] tl = 0, input logic [7:0] tb = 0,
                     input logic cf = 0, input logic cu = 0);
    @(negedge clk);
    push_valid = psh; pop_valid = pp; push_addr = d;
    ptr_wr_en = pwe; ptr_wr_val = pv;
    tos_wr_en = twe; tos_wr_lane = tl; tos_wr_byte = tb;
    clr_full = cf; clr_underflow = cu;
    #1;
    pop_seen = pop_addr; rdy_seen = pop_ready;
    @(posedge clk); #1;
    push_valid = 0; pop_valid = 0; ptr_wr_en = 0; tos_wr_en = 0;
    clr_full = 0; clr_underflow = 0;
  endtask

  typedef struct packed {
    logic [1:0]  op;     // bit0 push, bit1 pop
    logic [20:0] data;
    logic [4:0]  e_ptr;
    logic [20:0] e_tos;
    logic [20:0] e_pop;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 21'h000D58, 5'd1, 21'h000D58, 21'h0},
    '{2'b01, 21'h001A34, 5'd2, 21'h001A34, 21'h0},
    '{2'b10, 21'h0,      5'd1, 21'h000D58, 21'h001A34},
    '{2'b01, 21'h1FFFFF, 5'd2, 21'h1FFFFF, 21'h0},
    '{2'b11, 21'h012345, 5'd3, 21'h012345, 21'h0},
    '{2'b10, 21'h0,      5'd2, 21'h1FFFFF, 21'h012345},
    '{2'b10, 21'h0,      5'd1, 21'h000D58, 21'h1FFFFF},
    '{2'b10, 21'h0,      5'd0, 21'h0,      21'h000D58},
    '{2'b10, 21'h0,      5'd0, 21'h0,      21'h0}
  };

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ptr", 32'(ptr_val), 0);
    chk("R1 flags", {full, underflow, rst_req}, 0);
    chk("R1 tos", 32'(tos_word()), 0);

    // Table: R2, R3, R7, R11
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].op[0], VEC[i].op[1], VEC[i].data);
      chk($sformatf("R2/R3 row%0d ptr", i), 32'(ptr_val), 32'(VEC[i].e_ptr));
      chk($sformatf("R2/R3 row%0d tos", i), 32'(tos_word()), 32'(VEC[i].e_tos));
      if (VEC[i].op == 2'b10)
        chk($sformatf("R3/R7 row%0d pop", i), 32'(pop_seen), 32'(VEC[i].e_pop));
      if (VEC[i].op == 2'b11)
        chk("R11 pop_ready low", 32'(rdy_seen), 0);
    end

    // R7 sticky underflow and clear
    chk("R7 underflow set", 32'(underflow), 1);
    cyc(0, 0, 0);
    chk("R7 underflow sticky", 32'(underflow), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R7 underflow cleared", 32'(underflow), 0);

    // R10 lane write at pointer 0 ignored
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'hAA);
    chk("R10 write ignored", 32'(tos_word()), 0);

    // R8 pointer writes
    cyc(0, 0, 0, 1, 5'd3);
    chk("R8 ptr load", 32'(ptr_val), 3);
    cyc(0, 1, 0, 1, 5'd9);
    chk("R8 ignored under pop", 32'(ptr_val), 2);
    cyc(0, 0, 0, 1, 5'd0);
    chk("R8 ptr to zero", 32'(ptr_val), 0);

    // R9 lane writes
    cyc(1, 0, 21'h0);
    cyc(0, 0, 0, 0, 0, 1, 2'd2, 8'hFF);
    chk("R9 upper narrow", 32'(tos_upper), 32'h1F);
    chk("R9 upper word", 32'(tos_word()), 32'h1F0000);
    cyc(0, 0, 0, 0, 0, 1, 2'd0, 8'h5A);
    cyc(0, 0, 0, 0, 0, 1, 2'd1, 8'h3C);
    chk("R9 merged", 32'(tos_word()), 32'h1F3C5A);
    cyc(0, 0, 0, 0, 0, 1, 2'd3, 8'h00);
    chk("R9 lane 3 ignored", 32'(tos_word()), 32'h1F3C5A);
    cyc(0, 1, 0);
    chk("R9 pop lanes", 32'(pop_seen), 32'h1F3C5A);

    // R5 overflow with reset request
    do_reset();
    ovf_rst_en = 1;
    for (int i = 0; i < 30; i++) cyc(1, 0, 21'(32'h200 + i));
    chk("R5 ptr before", 32'(ptr_val), 30);
    chk("R4 full not yet", 32'(full), 0);
    cyc(1, 0, 21'h0F00D);
    chk("R5 rst_req", 32'(rst_req), 1);
    chk("R5 ptr zeroed", 32'(ptr_val), 0);
    chk("R4 full set", 32'(full), 1);
    cyc(0, 0, 0);
    chk("R5 rst_req one cycle", 32'(rst_req), 0);
    cyc(0, 0, 0, 1, 5'd31);
    chk("R5 entry 31 stored", 32'(tos_word()), 32'h0F00D);
    chk("R4 full sticky", 32'(full), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R4 full cleared", 32'(full), 0);

    // R6 saturating overflow
    ovf_rst_en = 0;
    cyc(0, 0, 0, 1, 5'd0);
    for (int i = 0; i < 31; i++) cyc(1, 0, 21'(32'h100 + i));
    chk("R6 ptr at top", 32'(ptr_val), 31);
    chk("R6 full", 32'(full), 1);
    chk("R6 no rst_req", 32'(rst_req), 0);
    cyc(1, 0, 21'h0ABCDE);
    chk("R6 ptr held", 32'(ptr_val), 31);
    chk("R6 no overwrite", 32'(tos_word()), 32'h11E);
    chk("R6 still no rst_req", 32'(rst_req), 0);
    cyc(0, 1, 0);
    chk("R6 pop top", 32'(pop_seen), 32'h11E);
    chk("R3 ptr after top pop", 32'(ptr_val), 30);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule